// File: doc/BRIEF.md
# Table-Driven Sequenced Adder

The block walks through two fixed 16-entry tables of 8-bit operands and adds the pair found at each index. A free-running counter chooses the index. Only the counter's top four bits form the index, so each index stays in place for many clock cycles, long enough for a slow observer to follow. A single direction input sets whether the counter runs upward or downward.

Both tables are synchronous read memories held inside the block, and they are clocked with the counter. Their two registered words go to an eight-cell ripple-carry adder with its carry-in tied low. The block drives out the 8-bit sum and the final carry. The parameter `CNT_W` sets the counter width, which is 30 by default. A smaller value shortens the time each index is held and leaves the index slicing unchanged.

Top module: `table_adder_seq`

## Requirements
- R1: While `rst_n` is low, the counter and both registered table words are cleared, so `sum` is 0 and `carry_out` is 0.
- R2: The table index is bits `CNT_W-1` down to `CNT_W-4` of the counter, so one index is held for 2^(CNT_W-4) consecutive cycles while the direction does not change.
- R3: With `dir_up` = 1 the counter adds one per clock. Table A holds, for index 0 to 15: 0,2,3,8,116,255,155,255,0,1,2,3,1,2,3,4. Table B holds, for index 0 to 15: 0,3,7,102,94,55,255,255,1,2,3,4,0,1,2,3.
- R4: With `dir_up` = 0 the counter subtracts one per clock.
- R5: Counting down from zero wraps the counter to all ones, which selects index 15 (sum 7).
- R6: Counting up from all ones wraps the counter to zero, which selects index 0 (sum 0).
- R7: `{carry_out, sum}` equals A + B + 0 as a 9-bit value. Indices 5, 6 and 7 give a carry-out of 1 with sums 54, 154 and 254.
- R8: The output reflects the index that was in place one clock earlier, because the table read is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the table reads |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| sum | output | 8 | Sum of the two table words |
| carry_out | output | 1 | Carry out of the top adder cell |

## Verification
A counter that steps wrongly or wraps badly shows up at the ports as a wrong table pair. That error is visible once the faulty index has passed through the table register, which is one clock after the index changes. A broken carry chain or a wrong table entry shows up as a wrong sum or carry on the first cycle that index is read. Indices 5 to 7 expose the carry-out. The stepping is checked with a short counter width, so every index and both wraps are reached within a few hundred cycles.

// File: rtl/table_adder_seq.sv
module table_adder_seq #(
  parameter int CNT_W = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_up,
  output logic [7:0] sum,
  output logic       carry_out
);
  localparam int IDX_W = 4;
  localparam int DW    = 8;

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rd_a, rd_b;
  logic [DW:0]      cy;

  function automatic logic [DW-1:0] lut_a(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return 8'd0;
      4'd1:  return 8'd2;
      4'd2:  return 8'd3;
      4'd3:  return 8'd8;
      4'd4:  return 8'd116;
      4'd5:  return 8'd255;
      4'd6:  return 8'd155;
      4'd7:  return 8'd255;
      4'd8:  return 8'd0;
      4'd9:  return 8'd1;
      4'd10: return 8'd2;
      4'd11: return 8'd3;
      4'd12: return 8'd1;
      4'd13: return 8'd2;
      4'd14: return 8'd3;
      default: return 8'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] lut_b(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:  return 8'd0;
      4'd1:  return 8'd3;
      4'd2:  return 8'd7;
      4'd3:  return 8'd102;
      4'd4:  return 8'd94;
      4'd5:  return 8'd55;
      4'd6:  return 8'd255;
      4'd7:  return 8'd255;
      4'd8:  return 8'd1;
      4'd9:  return 8'd2;
      4'd10: return 8'd3;
      4'd11: return 8'd4;
      4'd12: return 8'd0;
      4'd13: return 8'd1;
      4'd14: return 8'd2;
      default: return 8'd3;
    endcase
  endfunction

  assign idx = cnt[CNT_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      cnt  <= dir_up ? cnt + 1'b1 : cnt - 1'b1;
      rd_a <= lut_a(idx);
      rd_b <= lut_b(idx);
    end
  end

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < DW; i++) begin : g_fa
    assign sum[i]  = rd_a[i] ^ rd_b[i] ^ cy[i];
    assign cy[i+1] = (rd_a[i] & rd_b[i]) | (rd_b[i] & cy[i]) | (rd_a[i] & cy[i]);
  end

  assign carry_out = cy[DW];
endmodule

// File: rtl/table_adder_seq_chk.sv
module table_adder_seq_chk #(
  parameter int CNT_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_up,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       ra,
  input logic [7:0]       rb,
  input logic [7:0]       sum,
  input logic             co
);
  localparam int LOW = CNT_W - 4;

  logic [3:0] idx;
  assign idx = cnt[CNT_W-1 -: 4];

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dir_up)) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dir_up)) |-> cnt == CNT_W'($past(cnt) - 1'b1));

  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(idx)) |-> (cnt[LOW-1:0] == '0 || &cnt[LOW-1:0]));

  assert_adder_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {co, sum} == {1'b0, ra} + {1'b0, rb});

  assert_one_cycle_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(idx) == $past(idx, 2)) |-> $stable({co, sum}));
endmodule

bind table_adder_seq table_adder_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .cnt(cnt),
  .ra(rd_a), .rb(rd_b), .sum(sum), .co(carry_out)
);

// File: tb/tb_table_adder_seq.sv
module tb_table_adder_seq;
  localparam int PERIOD = 10;
  localparam int TB_W   = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_up = 1'b1;
  logic [7:0] sum;
  logic       carry_out;

  int errors = 0;
  int checks = 0;
  int carries = 0;
  string phase = "R1";

  logic [TB_W-1:0] m = '0;
  logic [8:0] expq[$];

  table_adder_seq #(.CNT_W(TB_W)) dut (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .sum(sum), .carry_out(carry_out)
  );

  always #(PERIOD/2) clk = ~clk;

  int ta[16] = '{0,2,3,8,116,255,155,255,0,1,2,3,1,2,3,4};
  int tb[16] = '{0,3,7,102,94,55,255,255,1,2,3,4,0,1,2,3};

  task automatic push_expect(input logic [3:0] i);
    expq.push_back(9'(ta[i] + tb[i]));
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      push_expect(m[TB_W-1 -: 4]);
      m = dir_up ? m + 1'b1 : m - 1'b1;
    end
  end

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [8:0] e;
      string tag;
      e = expq.pop_front();
      tag = e[8] ? "R7" : phase;
      if (e[8]) carries++;
      checks++;
      if ({carry_out, sum} !== e) begin
        errors++;
        $display("FAIL %s: sum/carry got %0d/%0d expected %0d/%0d",
                 tag, sum, carry_out, e[7:0], e[8]);
      end
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sum !== 8'd0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset output got %0d/%0d expected 0/0", sum, carry_out);
    end
    phase = "R5"; dir_up = 1'b0; rst_n = 1'b1;
    repeat (12) @(negedge clk);
    phase = "R4";
    repeat (40) @(negedge clk);
    phase = "R6"; dir_up = 1'b1;
    repeat (80) @(negedge clk);
    phase = "R3";
    repeat (64) @(negedge clk);
    phase = "R2";
    repeat (30) @(negedge clk);
    phase = "R8";
    for (int k = 0; k < 30; k++) begin
      dir_up = ~dir_up;
      @(negedge clk);
    end
    dir_up = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (carries == 0) begin
      errors++;
      $display("FAIL R7: carry-out cases seen got %0d expected >0", carries);
    end
    report();
  end
endmodule